// File: doc/BRIEF.md
# Active Shield Sequencer and Register Slave

This block is the software-facing control point of an active anti-probing shield. A processor writes a 128-bit cipher key and a 128-bit starting vector into it one byte at a time. It then loads the vector into the keystream core, switches the shield on and sets a pacing value. While the shield runs, the block asks the core for one keystream word at a time. Each time a word arrives, the block issues a single step to the mesh drive and compare path. Each step selects one packet of mesh lines through a cyclic index and a one-hot enable. A mismatch that the comparator reports during a step is latched into a sticky per-packet alarm bit, which software reads back.

The pacing value forces a minimum distance between consecutive steps. A larger value slows the mesh toggling and saves power, at the cost of slower detection. Software can switch the shield off while nothing sensitive is running. A fresh vector load restarts the packet index.

The controller is a four-state machine:
- IDLE: inactive.
- LOAD_IV: pulses the vector load into the core.
- GENERATE: waits for the core's valid pulse.
- DISPATCH: waits for the pacing counter, then steps.

Its transitions are:
- Any state moves to LOAD_IV on a vector-commit write.
- IDLE moves to GENERATE when the shield is enabled and a vector has been loaded since reset.
- LOAD_IV moves to GENERATE if the shield is enabled, otherwise to IDLE.
- GENERATE moves to DISPATCH on valid.
- DISPATCH moves back to GENERATE on the step.
- GENERATE and DISPATCH move to IDLE when the shield is disabled.

Top module: `shield_ctrl`

## Requirements
- R1: After reset, no step or core request is issued, the packet index is 0, and the control (0x21), pacing (0x22) and status (0x23) addresses read 0.
- R2: A write to address i (0..15) sets byte i of the key output (bits 8i+7..8i). These addresses read back 0. Writing the command address 0x20 with bit 0 set raises the key-load strobe for exactly the one cycle after the write.
- R3: A write to address 16+i sets byte i of the vector output. Writing 0x20 with bit 1 set raises the vector-load strobe in the cycle after the write, restarts the packet index at 0, and issues a core request in that same cycle if the shield is enabled. The restart applies whether the shield is idle or running.
- R4: Bit 0 of address 0x21 enables the shield. While no vector has been loaded since reset, enabling has no effect: no core request and no step appear.
- R5: Once the shield is enabled and loaded, a core request is issued on entry to GENERATE. Every step cycle also carries the request for the next word. Each valid pulse received in GENERATE leads to exactly one step.
- R6: Steps are never in adjacent cycles. With pacing value D at address 0x22 and a core that raises valid L+1 cycles after the request cycle, consecutive steps are max(D+1, L+2) cycles apart. With D=0, the step comes in the cycle after valid.
- R7: The packet index counts 0,1,...,NPKT-1 and wraps to 0, advancing once per step. The mesh enable is one-hot with bit index set during a step and is all zero otherwise.
- R8: In the cycle after the shield is disabled, neither steps nor requests appear, and valid pulses have no effect until the shield is enabled again.
- R9: Status bit k (address 0x23) is set when a mismatch is reported during a step of packet k, and it stays set until reset. The control and pacing addresses read back their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ks_key | output | 128 | Staged cipher key |
| ks_key_ld | output | 1 | One-cycle key load strobe |
| ks_iv | output | 128 | Staged starting vector |
| ks_iv_ld | output | 1 | Vector load strobe (LOAD_IV state) |
| ks_req | output | 1 | Request for the next keystream word |
| ks_valid | input | 1 | Keystream word ready pulse |
| cmp_mismatch | input | 1 | Comparator mismatch for the packet being stepped |
| mesh_step | output | 1 | Step strobe to the mesh drive/compare path |
| mesh_idx | output | 3 | Current packet index |
| mesh_en | output | 5 | One-hot packet enable during a step |

## Verification
Key and vector strobes are due in the cycle after the write edge. The bench samples them at the falling edge just after its write task drops the strobe, and confirms the pulse has ended one cycle later. Register reads are combinational, so the bench samples them one time unit after it sets the address. Step timing is checked against the formula in R6. A monitor timestamps every step at the falling edge and compares the gap between consecutive steps within one enabled run exactly against the expected spacing. The gap record is cleared whenever the vector is reloaded or the shield is re-enabled. Mismatches are driven mid-cycle in the step cycle so that the edge closing that cycle samples them.

// File: rtl/shield_ctrl_pkg.sv
package shield_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD_IV  = 2'd1,
        ST_GENERATE = 2'd2,
        ST_DISPATCH = 2'd3
    } shield_state_t;

    // command register bit positions
    localparam int CMD_KEY_BIT = 0;
    localparam int CMD_IV_BIT  = 1;

endpackage

// File: rtl/shield_ctrl_regs.sv
module shield_ctrl_regs #(
    parameter int BYTES  = 16,
    parameter int NPKT   = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [8*BYTES-1:0]    key_q,
    output logic [8*BYTES-1:0]    iv_q,
    output logic                  key_ld,
    output logic                  iv_go,
    output logic                  en_q,
    output logic [DATA_W-1:0]     div_q,
    input  logic                  step,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  mismatch
);
    import shield_ctrl_pkg::*;

    localparam logic [ADDR_W-1:0] A_IV_BASE = ADDR_W'(BYTES);
    localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(2*BYTES);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(2*BYTES+1);
    localparam logic [ADDR_W-1:0] A_DIV     = ADDR_W'(2*BYTES+2);
    localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(2*BYTES+3);

    logic [NPKT-1:0] alarm_q;
    logic            cmd_wr;

    assign cmd_wr = bus_wr && (bus_addr == A_CMD);
    assign iv_go  = cmd_wr && bus_wdata[CMD_IV_BIT];

    // staged key and vector bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            iv_q  <= '0;
        end else if (bus_wr) begin
            for (int b = 0; b < BYTES; b++) begin
                if (bus_addr == ADDR_W'(b))
                    key_q[8*b +: 8] <= bus_wdata[7:0];
                if (bus_addr == ADDR_W'(b) + A_IV_BASE)
                    iv_q[8*b +: 8] <= bus_wdata[7:0];
            end
        end
    end

    // control, pacing and key-load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            div_q  <= '0;
            key_ld <= 1'b0;
        end else begin
            key_ld <= cmd_wr && bus_wdata[CMD_KEY_BIT];
            if (bus_wr && bus_addr == A_CTRL)
                en_q <= bus_wdata[0];
            if (bus_wr && bus_addr == A_DIV)
                div_q <= bus_wdata;
        end
    end

    // sticky per-packet alarm
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= '0;
        else if (step && mismatch)
            alarm_q[idx] <= 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)
            bus_rdata = DATA_W'(en_q);
        else if (bus_addr == A_DIV)
            bus_rdata = div_q;
        else if (bus_addr == A_STAT)
            bus_rdata = DATA_W'(alarm_q);
    end

    assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q)));

    assert_secret_unreadable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < A_CMD) |-> (bus_rdata == '0));

endmodule

// File: rtl/shield_ctrl_rate.sv
module shield_ctrl_rate #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             ready
);
    localparam logic [DIV_W-1:0] GAP_MAX = '1;

    logic [DIV_W-1:0] gap_q;

    // cycles elapsed since the last step, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= GAP_MAX;
        else if (step)
            gap_q <= '0;
        else if (gap_q != GAP_MAX)
            gap_q <= gap_q + 1'b1;
    end

    assign ready = (gap_q >= div);

endmodule

// File: rtl/shield_ctrl_fsm.sv
module shield_ctrl_fsm #(
    parameter int NPKT  = 5,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              iv_go,
    input  logic              ks_valid,
    input  logic              ready,
    output logic              ks_req,
    output logic              ks_iv_ld,
    output logic              mesh_step,
    output logic [IDX_W-1:0]  mesh_idx,
    output logic [NPKT-1:0]   mesh_en
);
    import shield_ctrl_pkg::*;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NPKT-1);

    shield_state_t state_q, state_n;
    logic [IDX_W-1:0] idx_q;
    logic             iv_loaded_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (iv_go)                   state_n = ST_LOAD_IV;
                else if (en && iv_loaded_q)  state_n = ST_GENERATE;
            end
            ST_LOAD_IV: begin
                if (iv_go)                   state_n = ST_LOAD_IV;
                else if (en)                 state_n = ST_GENERATE;
                else                         state_n = ST_IDLE;
            end
            ST_GENERATE: begin
                if (iv_go)                   state_n = ST_LOAD_IV;
                else if (!en)                state_n = ST_IDLE;
                else if (ks_valid)           state_n = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                if (iv_go)                   state_n = ST_LOAD_IV;
                else if (!en)                state_n = ST_IDLE;
                else if (ready)              state_n = ST_GENERATE;
            end
            default:                         state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mesh_step = (state_q == ST_DISPATCH) && en && !iv_go && ready;
        ks_iv_ld  = (state_q == ST_LOAD_IV);
        ks_req    = (state_n == ST_GENERATE) && (state_q != ST_GENERATE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            iv_loaded_q <= 1'b0;
        end else if (state_q == ST_LOAD_IV) begin
            idx_q       <= '0;
            iv_loaded_q <= 1'b1;
        end else if (mesh_step) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    assign mesh_idx = idx_q;

    for (genvar p = 0; p < NPKT; p++) begin : g_pkt_en
        assign mesh_en[p] = mesh_step && (idx_q == IDX_W'(p));
    end

    assert_req_needs_iv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ks_req |-> (iv_loaded_q || state_q == ST_LOAD_IV));

    assert_disable_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE || state_q == ST_LOAD_IV));

    assert_iv_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ks_iv_ld |=> (mesh_idx == '0));

    assert_step_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mesh_step |=> !mesh_step);

    assert_en_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mesh_en) && (int'(mesh_idx) < NPKT));

endmodule

// File: rtl/shield_ctrl.sv
module shield_ctrl #(
    parameter int BYTES  = 16,
    parameter int NPKT   = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int KEY_W = 8 * BYTES,
    localparam int IDX_W = (NPKT > 1) ? $clog2(NPKT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [KEY_W-1:0]   ks_key,
    output logic               ks_key_ld,
    output logic [KEY_W-1:0]   ks_iv,
    output logic               ks_iv_ld,
    output logic               ks_req,
    input  logic               ks_valid,
    input  logic               cmp_mismatch,
    output logic               mesh_step,
    output logic [IDX_W-1:0]   mesh_idx,
    output logic [NPKT-1:0]    mesh_en
);
    logic              iv_go;
    logic              en_q;
    logic [DATA_W-1:0] div_q;
    logic              ready;

    shield_ctrl_regs #(
        .BYTES(BYTES), .NPKT(NPKT), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_q(ks_key), .iv_q(ks_iv), .key_ld(ks_key_ld),
        .iv_go(iv_go), .en_q(en_q), .div_q(div_q),
        .step(mesh_step), .idx(mesh_idx), .mismatch(cmp_mismatch)
    );

    shield_ctrl_rate #(.DIV_W(DATA_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .step(mesh_step),
        .div(div_q), .ready(ready)
    );

    shield_ctrl_fsm #(.NPKT(NPKT), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .iv_go(iv_go),
        .ks_valid(ks_valid), .ready(ready),
        .ks_req(ks_req), .ks_iv_ld(ks_iv_ld),
        .mesh_step(mesh_step), .mesh_idx(mesh_idx), .mesh_en(mesh_en)
    );

endmodule

// File: tb/shield_ctrl_bench.sv
module shield_ctrl_bench;
    localparam int NPKT  = 5;
    localparam int BYTES = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [127:0] ks_key, ks_iv;
    logic         ks_key_ld, ks_iv_ld, ks_req;
    logic         ks_valid = 1'b0;
    logic         cmp_mismatch = 1'b0;
    logic         mesh_step;
    logic [2:0]   mesh_idx;
    logic [4:0]   mesh_en;

    int total = 0, bad = 0;
    int cyc = 0, step_cnt = 0, req_cnt = 0;
    int exp_idx = 0, exp_gap = 0, prev_step = 0;
    bit have_prev = 0;
    int lat_cfg = 1;
    logic [7:0] exp_alarm = '0;
    logic [127:0] exp_key = '0, exp_iv = '0;

    shield_ctrl u_shield_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ks_key(ks_key), .ks_key_ld(ks_key_ld), .ks_iv(ks_iv), .ks_iv_ld(ks_iv_ld),
        .ks_req(ks_req), .ks_valid(ks_valid), .cmp_mismatch(cmp_mismatch),
        .mesh_step(mesh_step), .mesh_idx(mesh_idx), .mesh_en(mesh_en)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int spacing(input int d, input int l);
        return ((d + 1) > (l + 2)) ? (d + 1) : (l + 2);
    endfunction

    // keystream core model: valid arrives lat_cfg+1 cycles after the request cycle
    bit pend = 0;
    int cnt = 0;
    always @(posedge clk) begin
        ks_valid <= 1'b0;
        if (ks_req) begin
            pend <= 1; cnt <= lat_cfg;
        end else if (ks_iv_ld) begin
            pend <= 0;
        end else if (pend) begin
            if (cnt == 1) begin
                ks_valid <= 1'b1; pend <= 0;
            end else cnt <= cnt - 1;
        end
    end

    // step monitor
    always @(negedge clk) begin
        cyc++;
        if (ks_req) req_cnt++;
        cmp_mismatch = 1'b0;
        if (ks_iv_ld) begin
            exp_idx = 0; have_prev = 0;
        end
        if (mesh_step) begin
            chk(mesh_en == (5'd1 << exp_idx), "R7", "one-hot enable", mesh_en, 5'd1 << exp_idx);
            chk(mesh_idx == 3'(exp_idx), "R7", "packet index", mesh_idx, exp_idx);
            chk(ks_req == 1'b1, "R5", "request with step", ks_req, 1);
            if (have_prev)
                chk(cyc - prev_step == exp_gap, "R6", "step spacing", cyc - prev_step, exp_gap);
            prev_step = cyc; have_prev = 1;
            if ($urandom_range(0, 3) == 0) begin
                cmp_mismatch = 1'b1;
                exp_alarm[exp_idx] = 1'b1;
            end
            exp_idx = (exp_idx + 1) % NPKT;
            step_cnt++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_steps(input int n);
        int base = step_cnt;
        while (step_cnt < base + n) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic run_cfg(input int d, input int l, input int n);
        logic [7:0] v;
        int s0, r0;
        wr(8'h22, 8'(d));
        lat_cfg = l;
        exp_gap = spacing(d, l);
        have_prev = 0;
        wr(8'h21, 8'h01);
        wait_steps(n);
        rd(8'h21, v); chk(v == 8'h01, "R9", "control readback", v, 1);
        rd(8'h22, v); chk(v == 8'(d), "R9", "pacing readback", v, d);
        wr(8'h21, 8'h00);
        s0 = step_cnt; r0 = req_cnt;
        repeat (d + l + 30) @(negedge clk);
        #1;
        chk(step_cnt == s0, "R8", "steps after disable", step_cnt - s0, 0);
        chk(req_cnt == r0, "R8", "requests after disable", req_cnt - r0, 0);
        have_prev = 0;
    endtask

    initial begin
        logic [7:0] v;
        int s0, r0;
        void'($urandom(32'h5a17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(mesh_step == 0 && ks_req == 0, "R1", "no step/request", mesh_step, 0);
        chk(mesh_idx == 0, "R1", "index", mesh_idx, 0);
        rd(8'h21, v); chk(v == 0, "R1", "control", v, 0);
        rd(8'h22, v); chk(v == 0, "R1", "pacing", v, 0);
        rd(8'h23, v); chk(v == 0, "R1", "status", v, 0);

        // R2 key load
        for (int b = 0; b < BYTES; b++) begin
            logic [7:0] kb = 8'($urandom);
            exp_key[8*b +: 8] = kb;
            wr(8'(b), kb);
        end
        rd(8'h03, v); chk(v == 0, "R2", "key byte readback", v, 0);
        rd(8'h0f, v); chk(v == 0, "R2", "key last byte readback", v, 0);
        chk(ks_key == exp_key, "R2", "key output low word", ks_key[63:0], exp_key[63:0]);
        chk(ks_key_ld == 0, "R2", "key strobe idle", ks_key_ld, 0);
        wr(8'h20, 8'h01);
        chk(ks_key_ld == 1, "R2", "key strobe", ks_key_ld, 1);
        @(negedge clk); #1;
        chk(ks_key_ld == 0, "R2", "key strobe width", ks_key_ld, 0);

        // R4 enable before any vector load has no effect
        s0 = step_cnt; r0 = req_cnt;
        wr(8'h21, 8'h01);
        repeat (20) @(negedge clk);
        #1;
        chk(req_cnt == r0, "R4", "requests without vector", req_cnt - r0, 0);
        chk(step_cnt == s0, "R4", "steps without vector", step_cnt - s0, 0);
        wr(8'h21, 8'h00);

        // R3 vector load while idle
        for (int b = 0; b < BYTES; b++) begin
            logic [7:0] ib = 8'($urandom);
            exp_iv[8*b +: 8] = ib;
            wr(8'(16 + b), ib);
        end
        rd(8'h15, v); chk(v == 0, "R2", "vector byte readback", v, 0);
        chk(ks_iv == exp_iv, "R3", "vector output low word", ks_iv[63:0], exp_iv[63:0]);
        wr(8'h20, 8'h02);
        chk(ks_iv_ld == 1, "R3", "vector strobe", ks_iv_ld, 1);
        chk(ks_req == 0, "R3", "no request while disabled", ks_req, 0);
        @(negedge clk); #1;
        chk(ks_iv_ld == 0, "R3", "vector strobe width", ks_iv_ld, 0);
        chk(mesh_idx == 0, "R3", "index after load", mesh_idx, 0);

        // R5 request on entry after enable
        r0 = req_cnt;
        wr(8'h22, 8'h00);
        lat_cfg = 1; exp_gap = spacing(0, 1); have_prev = 0;
        wr(8'h21, 8'h01);
        @(negedge clk); #1;
        chk(req_cnt == r0 + 1, "R5", "request on enable", req_cnt - r0, 1);
        wait_steps(6);
        wr(8'h21, 8'h00);
        have_prev = 0;
        repeat (10) @(negedge clk);

        // directed corner cases of R6
        run_cfg(0, 1, 7);
        run_cfg(0, 6, 6);
        run_cfg(20, 1, 6);
        run_cfg(255, 2, 3);
        // constrained random configurations
        for (int k = 0; k < 5; k++)
            run_cfg($urandom_range(0, 12), $urandom_range(1, 8), 8);

        // R3 restart while running
        wr(8'h22, 8'h03);
        lat_cfg = 2; exp_gap = spacing(3, 2); have_prev = 0;
        wr(8'h21, 8'h01);
        wait_steps(7);
        wr(8'h20, 8'h02);
        chk(ks_iv_ld == 1, "R3", "vector strobe while running", ks_iv_ld, 1);
        chk(ks_req == 1, "R3", "request with reload", ks_req, 1);
        @(negedge clk); #1;
        chk(mesh_idx == 0, "R3", "index restart while running", mesh_idx, 0);
        wait_steps(4);
        wr(8'h21, 8'h00);

        // R9 status
        rd(8'h23, v);
        chk(v == exp_alarm, "R9", "alarm status", v, exp_alarm);
        rd(8'h23, v);
        chk(v == exp_alarm, "R9", "alarm status held", v, exp_alarm);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule